// File: doc/BRIEF.md
# Power-Up Configuration Select Sequencer

This block runs the start-up of a programmable clock device. It holds the chip in reset while power settles. It then reads one strap level to decide what two shared pins mean. Next it copies one of four stored configuration banks, word by word, into the working register file. Only after that does it open the serial programming path and ask the PLL to lock. Any write made over the serial path lives only in the register file. Every loss of power-good runs the whole sequence again, so the stored bank replaces those writes.

The raw power-good input clears everything at once when it falls. Its rising edge is released through a synchroniser, `SYNC_STAGES` flops deep (default 2), and then a power-on timer counts `POR_CYCLES` clocks. When the timer expires, the block samples the strap pin, the two shared pins and the address-select input. From that point the strap pin becomes the reference-clock output and its output enable is driven high. The bank memory is modelled outside the block and answers a read one cycle after it is issued.

Serial writes arrive on a valid/ready port. `ser_ready` stays low for the whole time `busy` is high, so no transfer can take place during start-up. A requester may hold or drop `ser_valid` in that time without any effect. A transfer happens in a cycle where `ser_valid` and `ser_ready` are both high, and that write shows on the register-file port in the same cycle.

Top module: `cfg_boot_seq`

## Requirements
- R1: The power-on interval lasts min(`POR_CYCLES`, `POR_MAX_CYCLES`) clocks after synchronised release. `POR_MAX_CYCLES` defaults to 10 ms at 125 MHz. With the default two sync stages, `strap_oe` rises exactly interval+2 clocks after `pwr_good` rises.
- R2: `strap_in` is captured once, at the end of the power-on interval, and `hw_sel_mode` equals the captured value. Changes of `strap_in`, the shared pins or `addr_alt` after capture have no effect until the next power cycle.
- R3: With strap high, the loaded bank is {`sel_hi_sda`, `sel_lo_scl`}, where `sel_hi_sda` is bit 1. With strap low, bank 0 is loaded.
- R4: `strap_oe` is low in reset and during the power-on interval. It goes high in the cycle after capture and stays high until power-good drops. No bank read is issued before it is high.
- R5: The load issues reads for word addresses 0 to 2^`ADDR_W`-1 of the chosen bank, one per cycle, with `nvm_addr` = {bank, word}. Each word is written to `rf_wr_addr` = word one cycle after its read. `load_done` pulses only with the write of the last word.
- R6: `busy` is high from reset through the `load_done` cycle. `ser_en` is high, and `busy` is low, from the next cycle on.
- R7: `ser_ready` is low while `busy` is high, so serial requests during start-up never reach the register file. Once ready, a valid request is written to `rf_wr_addr`/`rf_wr_data` in the same cycle.
- R8: `pll_lock_req` is a single one-cycle pulse, one cycle after `ser_en` rises. It occurs once per power-up.
- R9: A low `pwr_good` resets at once: `busy`=1, and `ser_en`, `ser_ready`, `strap_oe`, `pll_lock_req` and `rf_wr_en` are all 0. The next start-up reloads every word, which overwrites serial writes.
- R10: `dev_addr` is `DEV_ADDR_ALT` when `addr_alt` was high at capture, otherwise `DEV_ADDR_BASE`.
- R11: In serial mode after capture, `ser_sda_o` follows `sel_hi_sda` and `ser_scl_o` follows `sel_lo_scl`. In select mode, and before capture, both are held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pwr_good | input | 1 | Raw power-good, low clears the block |
| strap_in | input | 1 | Level on the shared strap/clock pin |
| sel_hi_sda | input | 1 | Shared pin: select bit 1 or serial data |
| sel_lo_scl | input | 1 | Shared pin: select bit 0 or serial clock |
| addr_alt | input | 1 | Chooses the alternate serial device address |
| nvm_rd_en | output | 1 | Bank memory read strobe |
| nvm_addr | output | 2+ADDR_W | {bank, word} read address |
| nvm_rd_data | input | DATA_W | Word returned one cycle after the read |
| ser_valid | input | 1 | Serial write request valid |
| ser_ready | output | 1 | Serial write accepted when high |
| ser_addr | input | ADDR_W | Serial write register address |
| ser_data | input | DATA_W | Serial write data |
| ser_sda_o | output | 1 | Data line routed to the serial engine |
| ser_scl_o | output | 1 | Clock line routed to the serial engine |
| dev_addr | output | 7 | Serial device address in use |
| hw_sel_mode | output | 1 | Captured strap: 1 = pins are selects |
| rf_wr_en | output | 1 | Register-file write enable |
| rf_wr_addr | output | ADDR_W | Register-file write address |
| rf_wr_data | output | DATA_W | Register-file write data |
| load_done | output | 1 | Pulse with the last loaded word |
| busy | output | 1 | Start-up in progress |
| ser_en | output | 1 | Serial access open |
| pll_lock_req | output | 1 | One-cycle lock request pulse |
| strap_oe | output | 1 | Output enable of the strap pin as clock output |

## Verification
The bound checker watches, on every cycle, a set of ordering rules. The power-on window is bounded, the captured mode stays frozen, and the output enable is sticky. No bank read happens before capture. `load_done` only comes with the last address and it opens serial access. `ser_ready` stays closed while busy, and the lock request is a single pulse that follows `ser_en`. Some behaviour only the directed scenarios can show: the exact cycle counts from power-good, the bank chosen for each strap and pin pattern, and the data copied word for word. They also show that late changes on the strap and pins are ignored, that serial writes are lost across a power cycle, and that the pins are routed per mode.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
  localparam int BANK_W = 2;

  typedef struct packed {
    logic              hw_sel;
    logic [BANK_W-1:0] bank;
    logic              alt_addr;
  } strap_cfg_t;

  function automatic logic [BANK_W-1:0] pick_bank(input logic hw_sel,
                                                  input logic [BANK_W-1:0] pins);
    return hw_sel ? pins : '0;
  endfunction
endpackage

// File: rtl/cbs_reset_sync.sv
module cbs_reset_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic pwr_good,
  output logic rst_n
);
  localparam int NS = (SYNC_STAGES < 2) ? 2 : SYNC_STAGES;
  logic [NS-1:0] chain;

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) chain <= '0;
    else           chain <= {chain[NS-2:0], 1'b1};
  end

  assign rst_n = chain[NS-1];
endmodule

// File: rtl/cbs_por_timer.sv
module cbs_por_timer #(
  parameter int POR_CYCLES     = 40,
  parameter int POR_MAX_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expire
);
  localparam int EFF_RAW = (POR_CYCLES > POR_MAX_CYCLES) ? POR_MAX_CYCLES : POR_CYCLES;
  localparam int EFF     = (EFF_RAW < 1) ? 1 : EFF_RAW;
  localparam int CW      = $clog2(EFF + 1);

  logic [CW-1:0] cnt;
  logic          running;

  assign expire = running && (cnt == CW'(EFF - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      running <= 1'b1;
    end else if (running) begin
      if (expire) running <= 1'b0;
      else        cnt     <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cbs_strap_latch.sv
module cbs_strap_latch
  import cfg_boot_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       capture,
  input  logic       strap_in,
  input  logic       pin_hi,
  input  logic       pin_lo,
  input  logic       addr_alt,
  output strap_cfg_t cfg,
  output logic       captured,
  output logic       ser_sda_o,
  output logic       ser_scl_o
);
  logic serial_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg      <= '0;
      captured <= 1'b0;
    end else if (capture && !captured) begin
      cfg.hw_sel   <= strap_in;
      cfg.bank     <= pick_bank(strap_in, {pin_hi, pin_lo});
      cfg.alt_addr <= addr_alt;
      captured     <= 1'b1;
    end
  end

  assign serial_mode = captured && !cfg.hw_sel;
  assign ser_sda_o   = serial_mode ? pin_hi : 1'b1;
  assign ser_scl_o   = serial_mode ? pin_lo : 1'b1;
endmodule

// File: rtl/cbs_bank_loader.sv
module cbs_bank_loader
  import cfg_boot_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [BANK_W-1:0]        bank,
  output logic                     nvm_rd_en,
  output logic [BANK_W+ADDR_W-1:0] nvm_addr,
  input  logic [DATA_W-1:0]        nvm_rd_data,
  output logic                     wr_en,
  output logic [ADDR_W-1:0]        wr_addr,
  output logic [DATA_W-1:0]        wr_data,
  output logic                     done
);
  localparam logic [ADDR_W-1:0] LAST = {ADDR_W{1'b1}};

  logic              reading;
  logic [ADDR_W-1:0] idx;
  logic              wr_q;
  logic [ADDR_W-1:0] wr_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reading   <= 1'b0;
      idx       <= '0;
      wr_q      <= 1'b0;
      wr_addr_q <= '0;
    end else begin
      if (start) begin
        reading <= 1'b1;
        idx     <= '0;
      end else if (reading) begin
        idx <= idx + 1'b1;
        if (idx == LAST) reading <= 1'b0;
      end
      wr_q      <= reading;
      wr_addr_q <= idx;
    end
  end

  assign nvm_rd_en = reading;
  assign nvm_addr  = {bank, idx};
  assign wr_en     = wr_q;
  assign wr_addr   = wr_addr_q;
  assign wr_data   = nvm_rd_data;
  assign done      = wr_q && (wr_addr_q == LAST);
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq
  import cfg_boot_pkg::*;
#(
  parameter int         POR_CYCLES     = 40,
  parameter int         POR_MAX_CYCLES = 1250000,
  parameter int         SYNC_STAGES    = 2,
  parameter int         ADDR_W         = 4,
  parameter int         DATA_W         = 8,
  parameter logic [6:0] DEV_ADDR_BASE  = 7'h6A,
  parameter logic [6:0] DEV_ADDR_ALT   = 7'h68
) (
  input  logic                     clk,
  input  logic                     pwr_good,
  input  logic                     strap_in,
  input  logic                     sel_hi_sda,
  input  logic                     sel_lo_scl,
  input  logic                     addr_alt,
  output logic                     nvm_rd_en,
  output logic [BANK_W+ADDR_W-1:0] nvm_addr,
  input  logic [DATA_W-1:0]        nvm_rd_data,
  input  logic                     ser_valid,
  output logic                     ser_ready,
  input  logic [ADDR_W-1:0]        ser_addr,
  input  logic [DATA_W-1:0]        ser_data,
  output logic                     ser_sda_o,
  output logic                     ser_scl_o,
  output logic [6:0]               dev_addr,
  output logic                     hw_sel_mode,
  output logic                     rf_wr_en,
  output logic [ADDR_W-1:0]        rf_wr_addr,
  output logic [DATA_W-1:0]        rf_wr_data,
  output logic                     load_done,
  output logic                     busy,
  output logic                     ser_en,
  output logic                     pll_lock_req,
  output logic                     strap_oe
);
  logic              por_rst_n;
  logic              por_expire;
  strap_cfg_t        cfg;
  logic              ld_wr_en;
  logic [ADDR_W-1:0] ld_wr_addr;
  logic [DATA_W-1:0] ld_wr_data;
  logic              ser_en_q;
  logic              done_d;
  logic              lock_q;
  logic              ser_fire;

  cbs_reset_sync #(.SYNC_STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .pwr_good(pwr_good), .rst_n(por_rst_n)
  );

  cbs_por_timer #(.POR_CYCLES(POR_CYCLES), .POR_MAX_CYCLES(POR_MAX_CYCLES)) u_por (
    .clk(clk), .rst_n(por_rst_n), .expire(por_expire)
  );

  cbs_strap_latch u_strap (
    .clk(clk), .rst_n(por_rst_n), .capture(por_expire), .strap_in(strap_in),
    .pin_hi(sel_hi_sda), .pin_lo(sel_lo_scl), .addr_alt(addr_alt),
    .cfg(cfg), .captured(strap_oe), .ser_sda_o(ser_sda_o), .ser_scl_o(ser_scl_o)
  );

  cbs_bank_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_load (
    .clk(clk), .rst_n(por_rst_n), .start(por_expire), .bank(cfg.bank),
    .nvm_rd_en(nvm_rd_en), .nvm_addr(nvm_addr), .nvm_rd_data(nvm_rd_data),
    .wr_en(ld_wr_en), .wr_addr(ld_wr_addr), .wr_data(ld_wr_data), .done(load_done)
  );

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      ser_en_q <= 1'b0;
      done_d   <= 1'b0;
      lock_q   <= 1'b0;
    end else begin
      if (load_done) ser_en_q <= 1'b1;
      done_d <= load_done;
      lock_q <= done_d;
    end
  end

  assign ser_ready    = ser_en_q;
  assign ser_fire     = ser_valid && ser_en_q;
  assign ser_en       = ser_en_q;
  assign busy         = !ser_en_q;
  assign pll_lock_req = lock_q;
  assign rf_wr_en     = ld_wr_en || ser_fire;
  assign rf_wr_addr   = ser_fire ? ser_addr : ld_wr_addr;
  assign rf_wr_data   = ser_fire ? ser_data : ld_wr_data;
  assign dev_addr     = cfg.alt_addr ? DEV_ADDR_ALT : DEV_ADDR_BASE;
  assign hw_sel_mode  = cfg.hw_sel;
endmodule

// File: rtl/cfg_boot_chk.sv
module cfg_boot_chk #(
  parameter int POR_CYCLES     = 40,
  parameter int POR_MAX_CYCLES = 1250000,
  parameter int ADDR_W         = 4,
  parameter int DATA_W         = 8
) (
  input logic              clk,
  input logic              por_rst_n,
  input logic              strap_oe,
  input logic              hw_sel_mode,
  input logic              busy,
  input logic              ser_en,
  input logic              ser_valid,
  input logic              ser_ready,
  input logic [ADDR_W-1:0] ser_addr,
  input logic [DATA_W-1:0] ser_data,
  input logic              rf_wr_en,
  input logic [ADDR_W-1:0] rf_wr_addr,
  input logic [DATA_W-1:0] rf_wr_data,
  input logic              load_done,
  input logic              pll_lock_req,
  input logic              nvm_rd_en
);
  localparam int EFF_RAW = (POR_CYCLES > POR_MAX_CYCLES) ? POR_MAX_CYCLES : POR_CYCLES;
  localparam int EFF     = (EFF_RAW < 1) ? 1 : EFF_RAW;
  localparam int CW      = $clog2(EFF + 2) + 1;

  logic [CW-1:0] win;

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n)     win <= '0;
    else if (!strap_oe) win <= win + 1'b1;
  end

  AST_POR_WINDOW: assert property (@(posedge clk) disable iff (!por_rst_n)
    int'(win) <= EFF); // R1
  AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!por_rst_n)
    strap_oe |=> $stable(hw_sel_mode)); // R2
  AST_OE_STICKY: assert property (@(posedge clk) disable iff (!por_rst_n)
    strap_oe |=> strap_oe); // R4
  AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!por_rst_n)
    nvm_rd_en |-> strap_oe); // R4
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!por_rst_n)
    load_done |-> rf_wr_en && (rf_wr_addr == {ADDR_W{1'b1}})); // R5
  AST_DONE_BUSY: assert property (@(posedge clk) disable iff (!por_rst_n)
    load_done |-> busy); // R6
  AST_DONE_OPENS: assert property (@(posedge clk) disable iff (!por_rst_n)
    load_done |=> ser_en && !busy); // R6
  AST_EN_STICKY: assert property (@(posedge clk) disable iff (!por_rst_n)
    ser_en |=> ser_en); // R6
  AST_READY_CLOSED: assert property (@(posedge clk) disable iff (!por_rst_n)
    busy |-> !ser_ready); // R7
  AST_SER_LANDS: assert property (@(posedge clk) disable iff (!por_rst_n)
    (ser_valid && ser_ready) |-> rf_wr_en && rf_wr_addr == ser_addr && rf_wr_data == ser_data); // R7
  AST_LOCK_SINGLE: assert property (@(posedge clk) disable iff (!por_rst_n)
    pll_lock_req |=> !pll_lock_req); // R8
  AST_LOCK_AFTER_EN: assert property (@(posedge clk) disable iff (!por_rst_n)
    pll_lock_req |-> ser_en && $past(ser_en)); // R8
endmodule

bind cfg_boot_seq cfg_boot_chk #(
  .POR_CYCLES(POR_CYCLES), .POR_MAX_CYCLES(POR_MAX_CYCLES),
  .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .por_rst_n(por_rst_n), .strap_oe(strap_oe), .hw_sel_mode(hw_sel_mode),
  .busy(busy), .ser_en(ser_en), .ser_valid(ser_valid), .ser_ready(ser_ready),
  .ser_addr(ser_addr), .ser_data(ser_data), .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
  .rf_wr_data(rf_wr_data), .load_done(load_done), .pll_lock_req(pll_lock_req),
  .nvm_rd_en(nvm_rd_en)
);

// File: tb/cfg_boot_seq_bench.sv
`timescale 1ns/1ps
module cfg_boot_seq_bench;
  localparam int P  = 20;
  localparam int AW = 4;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam logic [6:0] A_BASE = 7'h6A;
  localparam logic [6:0] A_ALT  = 7'h68;

  logic clk = 1'b0;
  logic pwr_good, strap_in, sel_hi_sda, sel_lo_scl, addr_alt;
  logic nvm_rd_en;
  logic [AW+1:0] nvm_addr;
  logic [DW-1:0] nvm_rd_data;
  logic ser_valid, ser_ready;
  logic [AW-1:0] ser_addr;
  logic [DW-1:0] ser_data;
  logic ser_sda_o, ser_scl_o;
  logic [6:0] dev_addr;
  logic hw_sel_mode, rf_wr_en, load_done, busy, ser_en, pll_lock_req, strap_oe;
  logic [AW-1:0] rf_wr_addr;
  logic [DW-1:0] rf_wr_data;

  int vectors = 0;
  int miscompares = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cfg_boot_seq #(.POR_CYCLES(P), .ADDR_W(AW), .DATA_W(DW),
                 .DEV_ADDR_BASE(A_BASE), .DEV_ADDR_ALT(A_ALT)) u_cfg_boot_seq (
    .clk(clk), .pwr_good(pwr_good), .strap_in(strap_in), .sel_hi_sda(sel_hi_sda),
    .sel_lo_scl(sel_lo_scl), .addr_alt(addr_alt), .nvm_rd_en(nvm_rd_en),
    .nvm_addr(nvm_addr), .nvm_rd_data(nvm_rd_data), .ser_valid(ser_valid),
    .ser_ready(ser_ready), .ser_addr(ser_addr), .ser_data(ser_data),
    .ser_sda_o(ser_sda_o), .ser_scl_o(ser_scl_o), .dev_addr(dev_addr),
    .hw_sel_mode(hw_sel_mode), .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr),
    .rf_wr_data(rf_wr_data), .load_done(load_done), .busy(busy), .ser_en(ser_en),
    .pll_lock_req(pll_lock_req), .strap_oe(strap_oe)
  );

  function automatic logic [DW-1:0] bank_word(input int b, input int a);
    return DW'((b * 67 + a * 13 + 90) ^ (a << 3));
  endfunction

  // bank memory model: one-cycle read latency
  always @(posedge clk)
    if (nvm_rd_en) nvm_rd_data <= bank_word(int'(nvm_addr[AW+1:AW]), int'(nvm_addr[AW-1:0]));

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    pwr_good = 1'b0;
    #1;
    chk(busy === 1'b1, "R9", "busy in reset", int'(busy), 1);
    chk({ser_en, ser_ready, strap_oe, pll_lock_req, rf_wr_en} === 5'b0, "R9",
        "control outputs in reset", int'({ser_en, ser_ready, strap_oe, pll_lock_req, rf_wr_en}), 0);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_boot(input logic strap, input logic [1:0] sel, input logic alt,
                        input string req);
    int exp_bank, first_oe, first_en, done_cyc, done_cnt, lock_cyc, lock_cnt;
    int wr_cnt, bad_wr, leak;
    t_reset_state();
    strap_in = strap; {sel_hi_sda, sel_lo_scl} = sel; addr_alt = alt;
    ser_valid = 1'b1; ser_addr = '0; ser_data = 8'hEE;
    exp_bank = strap ? int'(sel) : 0;
    first_oe = -1; first_en = -1; done_cyc = -1; done_cnt = 0;
    lock_cyc = -1; lock_cnt = 0; wr_cnt = 0; bad_wr = 0; leak = 0;
    @(negedge clk);
    pwr_good = 1'b1;
    cyc = 0;
    for (int i = 0; i < P + N + 10; i++) begin
      @(negedge clk);
      if (strap_oe && first_oe < 0) begin
        first_oe = cyc;
        strap_in = ~strap; {sel_hi_sda, sel_lo_scl} = ~sel; addr_alt = ~alt;  // R2 late changes
      end
      if (ser_en && first_en < 0) first_en = cyc;
      if (load_done) begin done_cnt++; done_cyc = cyc; end
      if (pll_lock_req) begin lock_cnt++; lock_cyc = cyc; end
      if (busy && ser_ready) leak++;
      if (rf_wr_en) begin
        wr_cnt++;
        if (rf_wr_data !== bank_word(exp_bank, int'(rf_wr_addr)) ||
            cyc != P + 3 + int'(rf_wr_addr)) begin
          bad_wr++;
          $display("FAIL %s: word %0d data %0h at %0d expected %0h at %0d", req,
                   rf_wr_addr, rf_wr_data, cyc, bank_word(exp_bank, int'(rf_wr_addr)),
                   P + 3 + int'(rf_wr_addr));
        end
      end
      if (cyc == P + 2 + N) ser_valid = 1'b0;
    end
    chk(first_oe == P + 2, "R1", "strap_oe rise cycle", first_oe, P + 2);
    chk(hw_sel_mode === strap, "R2", "captured mode", int'(hw_sel_mode), int'(strap));
    chk(wr_cnt == N, "R5", "load write count", wr_cnt, N);
    vectors++; if (bad_wr != 0) miscompares++;  // R3 bank choice, R5 data and timing, R9 reload
    chk(done_cnt == 1 && done_cyc == P + 2 + N, "R5", "load_done cycle", done_cyc, P + 2 + N);
    chk(first_en == P + 3 + N, "R6", "ser_en rise cycle", first_en, P + 3 + N);
    chk(leak == 0, "R7", "ready while busy", leak, 0);
    chk(lock_cnt == 1 && lock_cyc == P + 4 + N, "R8", "lock pulse cycle", lock_cyc, P + 4 + N);
    chk(dev_addr === (alt ? A_ALT : A_BASE), "R10", "device address", int'(dev_addr),
        int'(alt ? A_ALT : A_BASE));
  endtask

  task automatic t_serial_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    ser_valid = 1'b1; ser_addr = a; ser_data = d;
    #1;
    chk(ser_ready === 1'b1 && rf_wr_en === 1'b1, "R7", "serial write enable",
        int'({ser_ready, rf_wr_en}), 3);
    chk(rf_wr_addr === a && rf_wr_data === d, "R7", "serial write data",
        int'(rf_wr_data), int'(d));
    @(negedge clk);
    ser_valid = 1'b0;
  endtask

  task automatic t_route(input logic serial);
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      {sel_hi_sda, sel_lo_scl} = 2'(v);
      #1;
      chk({ser_sda_o, ser_scl_o} === (serial ? 2'(v) : 2'b11), "R11", "pin routing",
          int'({ser_sda_o, ser_scl_o}), serial ? v : 3);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run hung, actual 200000 cycles expected fewer");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    pwr_good = 1'b1; strap_in = 1'b0; sel_hi_sda = 1'b0; sel_lo_scl = 1'b0;
    addr_alt = 1'b0; ser_valid = 1'b0; ser_addr = '0; ser_data = '0; nvm_rd_data = '0;
    #1 pwr_good = 1'b0;
    t_reset_state();                         // R9
    t_boot(1'b1, 2'b11, 1'b0, "R3");         // select mode, bank 3
    t_route(1'b0);                           // R11 select mode holds lines
    t_boot(1'b1, 2'b10, 1'b1, "R3");         // select mode, bank 2, alternate address
    t_boot(1'b0, 2'b11, 1'b1, "R3");         // serial mode forces bank 0
    t_route(1'b1);                           // R11 serial mode passes lines
    t_serial_write(4'd5, 8'h3C);             // R7
    t_boot(1'b0, 2'b01, 1'b0, "R9");         // reload overwrites word 5
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule